// File: doc/BRIEF.md
# UART FIFO trigger threshold generator

This block turns a UART's FIFO trigger configuration into two 6-bit thresholds, one for the receive FIFO and one for the transmit FIFO. It then raises a level request for each direction, which interrupt and DMA logic consume. Each direction has three inputs: a 4-bit trigger field, a 2-bit legacy trigger code, and a fine-granularity mode bit. Together they select one of three encodings: a fixed legacy table, multiples of four, or a 1-step value formed by joining the two fields.

The decoded thresholds and the trigger fields are registered, so a configuration change shows at the outputs on the clock edge that follows it. The receive request compares the receive FIFO occupancy with the receive threshold. The transmit request compares the transmit FIFO free space with the transmit threshold. Both comparisons are combinational from the registered thresholds, and a global enable gates both requests.

In fine mode, a setting with both fields zero is not supported. The block clamps that threshold to 1 and sets a sticky configuration-error flag. A registered 16-bit view of the trigger fields is provided, with its upper byte fixed at zero.

Top module: `uart_trig_thresh`

## Requirements
- R1: With rx_fine_i low and rx_trig_i zero, rx_thresh_o decodes rx_leg_i: code 0 gives 8, code 1 gives 16, code 2 gives 56 and code 3 gives 60.
- R2: With rx_fine_i low and rx_trig_i nonzero, rx_thresh_o equals rx_trig_i times 4, whatever rx_leg_i is.
- R3: With rx_fine_i high, rx_thresh_o equals {rx_trig_i, rx_leg_i}, with rx_trig_i in bits 5:2 and rx_leg_i in bits 1:0.
- R4: With tx_fine_i low and tx_trig_i zero, tx_thresh_o decodes tx_leg_i: code 0 gives 8, code 1 gives 16, code 2 gives 32 and code 3 gives 56.
- R5: With tx_fine_i low and tx_trig_i nonzero, tx_thresh_o equals tx_trig_i times 4. With tx_fine_i high, it equals {tx_trig_i, tx_leg_i}, with the trigger field in bits 5:2.
- R6: If a direction is in fine mode with both of its fields zero, that threshold becomes 1, never 0. cfg_err_o also goes high on the same edge. It then stays high until a reset, whatever the later configuration is.
- R7: trig_word_o reads as {8'h00, registered rx_trig_i, registered tx_trig_i}: the receive field is in bits 7:4, the transmit field is in bits 3:0, and the upper byte is always zero.
- R8: rx_req_o is high exactly when enable_i is high and rx_count_i is at least rx_thresh_o. It follows rx_count_i combinationally, without waiting for a clock edge.
- R9: tx_req_o is high exactly when enable_i is high and tx_space_i is at least tx_thresh_o. It follows tx_space_i combinationally.
- R10: While enable_i is low, both rx_req_o and tx_req_o are low, even when the count and the free space are 64.
- R11: A configuration change appears on the threshold outputs at the first rising clock edge after it, and not before. Until that edge, the old thresholds and requests hold.
- R12: Either the asynchronous rst_ni or a clock edge with srst_i high returns the block to its reset state: both thresholds 8, trig_word_o zero and cfg_err_o low. srst_i takes priority over a configuration captured on the same edge, including an unsupported one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| srst_i | input | 1 | Synchronous clear of thresholds, fields and error flag |
| enable_i | input | 1 | Global request enable |
| rx_trig_i | input | 4 | Receive trigger field |
| rx_leg_i | input | 2 | Receive legacy trigger code |
| rx_fine_i | input | 1 | Receive 1-step granularity mode |
| tx_trig_i | input | 4 | Transmit trigger field |
| tx_leg_i | input | 2 | Transmit legacy trigger code |
| tx_fine_i | input | 1 | Transmit 1-step granularity mode |
| rx_count_i | input | 7 | Receive FIFO occupancy, 0 to 64 |
| tx_space_i | input | 7 | Transmit FIFO free space, 0 to 64 |
| rx_thresh_o | output | 6 | Registered receive threshold |
| tx_thresh_o | output | 6 | Registered transmit threshold |
| rx_req_o | output | 1 | Receive request |
| tx_req_o | output | 1 | Transmit request |
| cfg_err_o | output | 1 | Sticky unsupported-configuration flag |
| trig_word_o | output | 16 | Registered trigger field view |

## Verification
Two pairs of functions can act in the same cycle. The first pair is the threshold update and the request comparison. The bench holds the occupancy constant while a new configuration is applied. It checks that the request keeps its old value before the clock edge and switches on that edge, when the new threshold lands. The second pair is the synchronous clear and an unsupported fine-mode configuration, which the bench presents on the same edge. It judges that the clear wins: cfg_err_o stays low, the threshold is back at 8, and the error flag still latches once the clear is released.

// File: rtl/uart_trig_pkg.sv
package uart_trig_pkg;
  localparam int unsigned FIELD_W = 4;
  localparam int unsigned LEG_W   = 2;
  localparam int unsigned TH_W    = FIELD_W + LEG_W;
  localparam int unsigned CNT_W   = TH_W + 1;
  localparam int unsigned NUM_LEG = 1 << LEG_W;
  localparam int unsigned NUM_CH  = 2;

  typedef logic [NUM_LEG-1:0][TH_W-1:0] leg_table_t;

  // index 0 = code 0
  localparam leg_table_t RX_LEG_TABLE = {6'd60, 6'd56, 6'd16, 6'd8};
  localparam leg_table_t TX_LEG_TABLE = {6'd56, 6'd32, 6'd16, 6'd8};

  typedef struct packed {
    logic               fine;
    logic [FIELD_W-1:0] trig;
    logic [LEG_W-1:0]   leg;
  } chan_cfg_t;
endpackage

// File: rtl/uart_trig_decode.sv
module uart_trig_decode
  import uart_trig_pkg::*;
#(
  parameter leg_table_t LEG_TABLE = RX_LEG_TABLE
) (
  input  chan_cfg_t       cfg_i,
  output logic [TH_W-1:0] thresh_o,
  output logic            bad_o
);
  logic [TH_W-1:0] fine_val;

  assign fine_val = {cfg_i.trig, cfg_i.leg};

  always_comb begin
    bad_o    = 1'b0;
    thresh_o = LEG_TABLE[cfg_i.leg];
    if (cfg_i.fine) begin
      if (fine_val == '0) begin
        thresh_o = TH_W'(1);
        bad_o    = 1'b1;
      end else begin
        thresh_o = fine_val;
      end
    end else if (cfg_i.trig != '0) begin
      thresh_o = {cfg_i.trig, {LEG_W{1'b0}}};
    end
  end
endmodule

// File: rtl/uart_trig_chan.sv
module uart_trig_chan
  import uart_trig_pkg::*;
#(
  parameter leg_table_t LEG_TABLE = RX_LEG_TABLE
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               srst_i,
  input  logic               enable_i,
  input  chan_cfg_t          cfg_i,
  input  logic [CNT_W-1:0]   level_i,
  output logic [TH_W-1:0]    thresh_o,
  output logic [FIELD_W-1:0] field_o,
  output logic               bad_o,
  output logic               req_o
);
  localparam logic [TH_W-1:0] RST_TH = LEG_TABLE[0];

  logic [TH_W-1:0]    thresh_d, thresh_q;
  logic [FIELD_W-1:0] field_q;

  uart_trig_decode #(.LEG_TABLE(LEG_TABLE)) u_dec (
    .cfg_i    (cfg_i),
    .thresh_o (thresh_d),
    .bad_o    (bad_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thresh_q <= RST_TH;
      field_q  <= '0;
    end else if (srst_i) begin
      thresh_q <= RST_TH;
      field_q  <= '0;
    end else begin
      thresh_q <= thresh_d;
      field_q  <= cfg_i.trig;
    end
  end

  assign thresh_o = thresh_q;
  assign field_o  = field_q;
  assign req_o    = enable_i && (level_i >= {1'b0, thresh_q});
endmodule

// File: rtl/uart_trig_thresh.sv
module uart_trig_thresh
  import uart_trig_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               srst_i,
  input  logic               enable_i,
  input  logic [FIELD_W-1:0] rx_trig_i,
  input  logic [LEG_W-1:0]   rx_leg_i,
  input  logic               rx_fine_i,
  input  logic [FIELD_W-1:0] tx_trig_i,
  input  logic [LEG_W-1:0]   tx_leg_i,
  input  logic               tx_fine_i,
  input  logic [CNT_W-1:0]   rx_count_i,
  input  logic [CNT_W-1:0]   tx_space_i,
  output logic [TH_W-1:0]    rx_thresh_o,
  output logic [TH_W-1:0]    tx_thresh_o,
  output logic               rx_req_o,
  output logic               tx_req_o,
  output logic               cfg_err_o,
  output logic [15:0]        trig_word_o
);
  localparam int unsigned RSVD_W = 16 - NUM_CH * FIELD_W;

  chan_cfg_t                        cfg   [NUM_CH];
  logic [CNT_W-1:0]                 level [NUM_CH];
  logic [TH_W-1:0]                  thr   [NUM_CH];
  logic [FIELD_W-1:0]               fld   [NUM_CH];
  logic [NUM_CH-1:0]                bad, req;
  logic                             err_q;

  // channel 0 = receive, channel 1 = transmit
  assign cfg[0]   = '{fine: rx_fine_i, trig: rx_trig_i, leg: rx_leg_i};
  assign cfg[1]   = '{fine: tx_fine_i, trig: tx_trig_i, leg: tx_leg_i};
  assign level[0] = rx_count_i;
  assign level[1] = tx_space_i;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    uart_trig_chan #(
      .LEG_TABLE(g == 0 ? RX_LEG_TABLE : TX_LEG_TABLE)
    ) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .srst_i   (srst_i),
      .enable_i (enable_i),
      .cfg_i    (cfg[g]),
      .level_i  (level[g]),
      .thresh_o (thr[g]),
      .field_o  (fld[g]),
      .bad_o    (bad[g]),
      .req_o    (req[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     err_q <= 1'b0;
    else if (srst_i) err_q <= 1'b0;
    else             err_q <= err_q | (|bad);
  end

  assign rx_thresh_o = thr[0];
  assign tx_thresh_o = thr[1];
  assign rx_req_o    = req[0];
  assign tx_req_o    = req[1];
  assign cfg_err_o   = err_q;
  assign trig_word_o = {{RSVD_W{1'b0}}, fld[0], fld[1]};
endmodule

// File: rtl/uart_trig_thresh_chk.sv
module uart_trig_thresh_chk
  import uart_trig_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               srst_i,
  input logic               enable_i,
  input logic [FIELD_W-1:0] rx_trig_i,
  input logic [LEG_W-1:0]   rx_leg_i,
  input logic               rx_fine_i,
  input logic [FIELD_W-1:0] tx_trig_i,
  input logic [LEG_W-1:0]   tx_leg_i,
  input logic               tx_fine_i,
  input logic [CNT_W-1:0]   rx_count_i,
  input logic [CNT_W-1:0]   tx_space_i,
  input logic [TH_W-1:0]    rx_thresh_o,
  input logic [TH_W-1:0]    tx_thresh_o,
  input logic               rx_req_o,
  input logic               tx_req_o,
  input logic               cfg_err_o,
  input logic [15:0]        trig_word_o
);
  assert_rx_fine_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!srst_i && rx_fine_i && {rx_trig_i, rx_leg_i} != '0)
      |=> rx_thresh_o == $past({rx_trig_i, rx_leg_i}));

  assert_tx_fine_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!srst_i && tx_fine_i && {tx_trig_i, tx_leg_i} != '0)
      |=> tx_thresh_o == $past({tx_trig_i, tx_leg_i}));

  assert_clamp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!srst_i && rx_fine_i && {rx_trig_i, rx_leg_i} == '0)
      |=> (cfg_err_o && rx_thresh_o == TH_W'(1)));

  assert_err_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_err_o && !srst_i) |=> cfg_err_o);

  assert_nonzero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_thresh_o != '0) && (tx_thresh_o != '0));

  assert_rx_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_req_o |-> (rx_count_i >= {1'b0, rx_thresh_o}));

  assert_tx_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_o |-> (tx_space_i >= {1'b0, tx_thresh_o}));

  assert_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |-> !(rx_req_o || tx_req_o));

  assert_clear_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (!cfg_err_o && rx_thresh_o == TH_W'(8) && tx_thresh_o == TH_W'(8)
                && trig_word_o == '0));
endmodule

bind uart_trig_thresh uart_trig_thresh_chk u_chk (.*);

// File: tb/uart_trig_thresh_test.sv
module uart_trig_thresh_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0, srst = 1'b0, en = 1'b1;
  logic [3:0] rx_trig = '0, tx_trig = '0;
  logic [1:0] rx_leg = '0, tx_leg = '0;
  logic       rx_fine = 1'b0, tx_fine = 1'b0;
  logic [6:0] rx_cnt = '0, tx_spc = '0;
  logic [5:0] rx_th, tx_th;
  logic       rx_req, tx_req, err;
  logic [15:0] word;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_trig_thresh uut (
    .clk_i(clk), .rst_ni(rst_n), .srst_i(srst), .enable_i(en),
    .rx_trig_i(rx_trig), .rx_leg_i(rx_leg), .rx_fine_i(rx_fine),
    .tx_trig_i(tx_trig), .tx_leg_i(tx_leg), .tx_fine_i(tx_fine),
    .rx_count_i(rx_cnt), .tx_space_i(tx_spc),
    .rx_thresh_o(rx_th), .tx_thresh_o(tx_th),
    .rx_req_o(rx_req), .tx_req_o(tx_req), .cfg_err_o(err), .trig_word_o(word)
  );

  // {rx_fine, rx_trig, rx_leg, tx_fine, tx_trig, tx_leg, exp_rx, exp_tx}
  localparam int NV = 9;
  localparam logic [25:0] VEC [NV] = '{
    {1'b0, 4'd0,  2'd0, 1'b0, 4'd0,  2'd0, 6'd8,  6'd8 },
    {1'b0, 4'd0,  2'd1, 1'b0, 4'd0,  2'd1, 6'd16, 6'd16},
    {1'b0, 4'd0,  2'd2, 1'b0, 4'd0,  2'd2, 6'd56, 6'd32},
    {1'b0, 4'd0,  2'd3, 1'b0, 4'd0,  2'd3, 6'd60, 6'd56},
    {1'b0, 4'd1,  2'd3, 1'b0, 4'd15, 2'd2, 6'd4,  6'd60},
    {1'b0, 4'd15, 2'd0, 1'b0, 4'd1,  2'd1, 6'd60, 6'd4 },
    {1'b1, 4'd0,  2'd1, 1'b1, 4'd15, 2'd3, 6'd1,  6'd63},
    {1'b1, 4'd15, 2'd3, 1'b1, 4'd2,  2'd1, 6'd63, 6'd9 },
    {1'b1, 4'd5,  2'd2, 1'b0, 4'd7,  2'd0, 6'd22, 6'd28}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    // reset state R12
    #20;
    chk("R12", "rx_th in reset", rx_th, 8);
    chk("R12", "tx_th in reset", tx_th, 8);
    chk("R12", "word in reset", word, 0);
    chk("R12", "err in reset", err, 0);
    chk("R8", "rx_req count 0", rx_req, 0);
    @(negedge clk);
    rst_n = 1'b1;
    tick();

    // table walk R1 R2 R3 R4 R5 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      logic [25:0] v;
      string rt, tt;
      v = VEC[i];
      rx_fine = v[25]; rx_trig = v[24:21]; rx_leg = v[20:19];
      tx_fine = v[18]; tx_trig = v[17:14]; tx_leg = v[13:12];
      tick();
      rt = v[25] ? "R3" : (v[24:21] != 0 ? "R2" : "R1");
      tt = (v[18] || v[17:14] != 0) ? "R5" : "R4";
      chk(rt, "rx_th", rx_th, int'(v[11:6]));
      chk(tt, "tx_th", tx_th, int'(v[5:0]));
      chk("R7", "word", word, int'({8'h00, v[24:21], v[17:14]}));
      chk("R6", "err clean", err, 0);
      rx_cnt = 7'(v[11:6]); tx_spc = 7'(v[5:0]);
      #1;
      chk("R8", "rx_req at thr", rx_req, 1);
      chk("R9", "tx_req at thr", tx_req, 1);
      rx_cnt = 7'(v[11:6]) - 7'd1; tx_spc = 7'(v[5:0]) - 7'd1;
      #1;
      chk("R8", "rx_req below", rx_req, 0);
      chk("R9", "tx_req below", tx_req, 0);
    end

    // R10: enable low with full levels
    rx_cnt = 7'd64; tx_spc = 7'd64;
    #1;
    chk("R8", "rx_req at 64", rx_req, 1);
    en = 1'b0;
    #1;
    chk("R10", "rx_req gated", rx_req, 0);
    chk("R10", "tx_req gated", tx_req, 0);
    en = 1'b1;

    // R11: config change and request evaluated around the same edge
    rx_fine = 0; rx_trig = 4'd0; rx_leg = 2'd0;
    tx_fine = 0; tx_trig = 4'd0; tx_leg = 2'd0;
    tick();
    rx_cnt = 7'd10; tx_spc = 7'd10;
    rx_trig = 4'd3; tx_trig = 4'd4;
    #1;
    chk("R11", "rx_th before edge", rx_th, 8);
    chk("R11", "rx_req before edge", rx_req, 1);
    chk("R11", "tx_req before edge", tx_req, 1);
    tick();
    chk("R11", "rx_th after edge", rx_th, 12);
    chk("R11", "rx_req after edge", rx_req, 0);
    chk("R11", "tx_th after edge", tx_th, 16);
    chk("R11", "tx_req after edge", tx_req, 0);

    // R6: unsupported rx fine setting, sticky flag
    rx_fine = 1; rx_trig = 0; rx_leg = 0;
    tick();
    chk("R6", "rx clamp", rx_th, 1);
    chk("R6", "err set", err, 1);
    rx_fine = 0; rx_trig = 4'd2;
    tick();
    tick();
    chk("R6", "err sticky", err, 1);
    chk("R2", "rx_th after bad", rx_th, 8);

    // R12: srst with an unsupported tx setting on the same edge
    tx_fine = 1; tx_trig = 0; tx_leg = 0;
    srst = 1;
    tick();
    chk("R12", "err cleared", err, 0);
    chk("R12", "tx_th cleared", tx_th, 8);
    chk("R12", "rx_th cleared", rx_th, 8);
    chk("R12", "word cleared", word, 0);
    srst = 0;
    tick();
    chk("R6", "tx clamp", tx_th, 1);
    chk("R6", "err set tx", err, 1);
    tx_spc = 7'd0;
    #1;
    chk("R9", "tx_req space 0", tx_req, 0);

    // async reset R12
    #2;
    rst_n = 0;
    #1;
    chk("R12", "async err", err, 0);
    chk("R12", "async tx_th", tx_th, 8);
    finish_run();
  end
endmodule